// File: doc/BRIEF.md
# Transmit Low-Power Idle Controller

This block sits on the transmit side of an Ethernet MAC. It decides when the transmitter may enter the low-power idle state and when it must leave it. Software sets four control bits: an idle enable, an automatic-entry enable, a transmit clock-gate enable and a link-up flag. It also writes one timer word. The word holds a link-stable time in milliseconds and a wake time in microseconds. Two free-running tick inputs, one per millisecond and one per microsecond, drive the two internal timers.

The controller enters idle only after the link flag has stayed set for the programmed number of millisecond ticks, while both enables are set and no frame is pending. A pending frame, or an enable being removed, takes the block out of idle and into a wake period. Transmission is allowed again only when the wake period has run out. If the link flag drops, the link timer is cleared and the block goes straight back to the active state.

The block drives four things: an idle-assert line toward the PHY interface, a transmit clock-stop request, a transmit-allowed flag, and its state code. It also gives one-cycle pulses when idle is entered and when idle is exited.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the state code is 0, idle-assert is low, transmit-allowed is high, the clock-stop request is low and both pulses are low.
- R2: The timer word carries the wake time in bits 15:0 as a count of microsecond ticks and the link-stable time in bits 25:16 as a count of millisecond ticks.
- R3: From the active state, the block moves to link-wait (code 1) one cycle after the idle enable, the automatic enable and the link flag are all high. If either enable is low, it stays in the active state (code 0).
- R4: Idle (code 2) is entered one cycle after the link-stable counter reaches the programmed count. The counter advances on millisecond ticks only while the link flag is set. A count of zero allows entry at once.
- R5: While a frame is pending, the block stays in link-wait even when the link-stable time has been met. It enters idle one cycle after the pending signal falls.
- R6: In idle, a pending frame or a cleared enable moves the block to wake (code 3) on the next cycle. In wake, idle-assert and transmit-allowed are both low.
- R7: With the microsecond tick high in every cycle, the wake state lasts exactly W+1 cycles for a wake count W. After that the block is active and transmission is allowed.
- R8: A low link flag in any state returns the block to active on the next cycle with idle-assert low. It also clears the link-stable counter, so a new entry needs the full count again.
- R9: The clock-stop request is high exactly when the block is in idle and the clock-gate enable is set.
- R10: The entry pulse is high for one cycle, in the first idle cycle. The exit pulse is high for one cycle, in the first cycle after idle.
- R11: The state code is ACTIVE=0, LINK_WAIT=1, IDLE=2, WAKE=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lpi_en | input | 1 | Idle enable |
| cfg_auto_en | input | 1 | Automatic-entry enable |
| cfg_gate_en | input | 1 | Allow transmit clock stop while idle |
| cfg_link_up | input | 1 | Link-up flag written by software |
| cfg_timer_word | input | 32 | Wake time [15:0] in µs, link-stable time [25:16] in ms |
| tick_ms | input | 1 | One-cycle millisecond tick |
| tick_us | input | 1 | One-cycle microsecond tick |
| tx_pending | input | 1 | A frame is waiting to be sent |
| lpi_assert | output | 1 | Idle signalling toward the PHY interface |
| txclk_gate_req | output | 1 | Transmit clock-stop request |
| tx_allowed | output | 1 | Normal transmission permitted |
| state_o | output | 2 | Current state code |
| lpi_entry_pulse | output | 1 | One-cycle pulse on idle entry |
| lpi_exit_pulse | output | 1 | One-cycle pulse on idle exit |

## Verification
The bench builds the block with its default counter widths: 16 bits for the wake count and 10 bits for the link-stable count. It does not need narrow widths to reach the corners, because it writes small values into the timer word. It uses a link-stable count of 3 and a wake count of 5, which are distinct so that swapped fields would show. It then uses zero for both counts, and a wake count of 200 to hold the block in wake long enough for a link drop. The microsecond tick is held high, so the wake length can be measured exactly in cycles. Millisecond ticks are pulsed one at a time, so the cycle of entry can be pinned to the final tick.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE    = 2'd0,
        ST_LINK_WAIT = 2'd1,
        ST_LPI       = 2'd2,
        ST_WAKE      = 2'd3
    } lpi_state_e;

    typedef struct packed {
        logic lpi_en;
        logic auto_en;
        logic gate_en;
        logic link_up;
    } lpi_ctrl_t;

    localparam int TIMER_WORD_W = 32;
    localparam int WAKE_LSB     = 0;
    localparam int LS_LSB       = 16;

    function automatic logic is_armed(input lpi_ctrl_t c);
        return c.lpi_en && c.auto_en;
    endfunction

endpackage

// File: rtl/eee_link_timer.sv
module eee_link_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_up,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             met
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !link_up)
            cnt_q <= '0;
        else if (tick && (cnt_q < target))
            cnt_q <= cnt_q + 1'b1;
    end

    assign met = link_up && (cnt_q >= target);

    // R8: a low link flag leaves no credit behind
    a_r8_no_credit_after_drop: assert property (@(posedge clk) disable iff (rst)
        (!link_up) |=> (cnt_q == '0 || $past(tick)));
endmodule

// File: rtl/eee_wake_timer.sv
module eee_wake_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start)
            cnt_q <= '0;
        else if (run && tick && (cnt_q < target))
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q >= target);

    // R7: each counted step is backed by a microsecond tick
    a_r7_count_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q) && cnt_q != '0) |-> $past(tick && run));
endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
    import eee_lpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lpi_ctrl_t  ctrl,
    input  logic       ls_met,
    input  logic       wake_done,
    input  logic       tx_pending,
    output lpi_state_e state_q,
    output logic       wake_start,
    output logic       entry_q,
    output logic       exit_q
);
    lpi_state_e state_d;
    logic       armed;

    assign armed = is_armed(ctrl);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:
                if (ctrl.link_up && armed) state_d = ST_LINK_WAIT;
            ST_LINK_WAIT:
                if (!ctrl.link_up || !armed)    state_d = ST_ACTIVE;
                else if (ls_met && !tx_pending) state_d = ST_LPI;
            ST_LPI:
                if (!ctrl.link_up)            state_d = ST_ACTIVE;
                else if (tx_pending || !armed) state_d = ST_WAKE;
            ST_WAKE:
                if (!ctrl.link_up || wake_done) state_d = ST_ACTIVE;
            default: state_d = ST_ACTIVE;
        endcase
    end

    assign wake_start = (state_q == ST_LPI) && (state_d == ST_WAKE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACTIVE;
            entry_q <= 1'b0;
            exit_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            entry_q <= (state_d == ST_LPI) && (state_q != ST_LPI);
            exit_q  <= (state_q == ST_LPI) && (state_d != ST_LPI);
        end
    end

    // R8: link loss always lands in the active state
    a_r8_link_drop: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.link_up) |=> (state_q == ST_ACTIVE));
    // R3, R4, R5: idle entry only with all conditions met
    a_r4_entry_cond: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LPI && $past(state_q) != ST_LPI)
        |-> $past(ls_met && armed && !tx_pending));
    // R6: wake is reached only from idle
    a_r6_wake_from_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAKE && $past(state_q) != ST_WAKE) |-> ($past(state_q) == ST_LPI));
    // R7: wake ends only on timer expiry or link loss
    a_r7_wake_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_WAKE && state_q == ST_ACTIVE)
        |-> ($past(wake_done) || !$past(ctrl.link_up)));
    // R10: pulses last one cycle
    a_r10_entry_single: assert property (@(posedge clk) disable iff (rst)
        entry_q |=> !entry_q);
    a_r10_exit_single: assert property (@(posedge clk) disable iff (rst)
        exit_q |=> !exit_q);
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int WAKE_W = 16,
    parameter int LS_W   = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_lpi_en,
    input  logic        cfg_auto_en,
    input  logic        cfg_gate_en,
    input  logic        cfg_link_up,
    input  logic [31:0] cfg_timer_word,
    input  logic        tick_ms,
    input  logic        tick_us,
    input  logic        tx_pending,
    output logic        lpi_assert,
    output logic        txclk_gate_req,
    output logic        tx_allowed,
    output logic [1:0]  state_o,
    output logic        lpi_entry_pulse,
    output logic        lpi_exit_pulse
);
    localparam int WAKE_MSB = WAKE_LSB + WAKE_W - 1;
    localparam int LS_MSB   = LS_LSB + LS_W - 1;

    lpi_ctrl_t        ctrl;
    lpi_state_e       state;
    logic [WAKE_W-1:0] wake_target;
    logic [LS_W-1:0]   ls_target;
    logic             ls_met, wake_done, wake_start, entry_q, exit_q;

    assign ctrl = '{lpi_en: cfg_lpi_en, auto_en: cfg_auto_en,
                    gate_en: cfg_gate_en, link_up: cfg_link_up};
    assign wake_target = cfg_timer_word[WAKE_MSB:WAKE_LSB];
    assign ls_target   = cfg_timer_word[LS_MSB:LS_LSB];

    eee_link_timer #(.CNT_W(LS_W)) u_link_timer (
        .clk(clk), .rst(rst), .link_up(ctrl.link_up), .tick(tick_ms),
        .target(ls_target), .met(ls_met)
    );

    eee_wake_timer #(.CNT_W(WAKE_W)) u_wake_timer (
        .clk(clk), .rst(rst), .start(wake_start), .run(state == ST_WAKE),
        .tick(tick_us), .target(wake_target), .done(wake_done)
    );

    eee_lpi_fsm u_fsm (
        .clk(clk), .rst(rst), .ctrl(ctrl), .ls_met(ls_met),
        .wake_done(wake_done), .tx_pending(tx_pending), .state_q(state),
        .wake_start(wake_start), .entry_q(entry_q), .exit_q(exit_q)
    );

    assign state_o         = state;
    assign lpi_assert      = (state == ST_LPI);
    assign tx_allowed      = (state == ST_ACTIVE) || (state == ST_LINK_WAIT);
    assign txclk_gate_req  = lpi_assert && ctrl.gate_en;
    assign lpi_entry_pulse = entry_q;
    assign lpi_exit_pulse  = exit_q;

    // R9: clock stop only while idle
    a_r9_gate_in_idle: assert property (@(posedge clk) disable iff (rst)
        txclk_gate_req |-> lpi_assert);
    // R10: entry pulse marks the first idle cycle
    a_r10_entry_first: assert property (@(posedge clk) disable iff (rst)
        lpi_entry_pulse |-> (lpi_assert && !$past(lpi_assert)));
    // R10: exit pulse marks the first cycle after idle
    a_r10_exit_first: assert property (@(posedge clk) disable iff (rst)
        lpi_exit_pulse |-> (!lpi_assert && $past(lpi_assert)));
endmodule

// File: tb/eee_lpi_ctrl_bench.sv
module eee_lpi_ctrl_bench;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_lpi_en = 0, cfg_auto_en = 0, cfg_gate_en = 0, cfg_link_up = 0;
    logic [31:0] cfg_timer_word = '0;
    logic tick_ms = 0, tick_us = 1, tx_pending = 0;
    logic lpi_assert, txclk_gate_req, tx_allowed, lpi_entry_pulse, lpi_exit_pulse;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    eee_lpi_ctrl u_eee_lpi_ctrl (
        .clk(clk), .rst(rst), .cfg_lpi_en(cfg_lpi_en), .cfg_auto_en(cfg_auto_en),
        .cfg_gate_en(cfg_gate_en), .cfg_link_up(cfg_link_up),
        .cfg_timer_word(cfg_timer_word), .tick_ms(tick_ms), .tick_us(tick_us),
        .tx_pending(tx_pending), .lpi_assert(lpi_assert),
        .txclk_gate_req(txclk_gate_req), .tx_allowed(tx_allowed),
        .state_o(state_o), .lpi_entry_pulse(lpi_entry_pulse),
        .lpi_exit_pulse(lpi_exit_pulse)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_times(input int ls, input int wk);
        cfg_timer_word = {6'd0, ls[9:0], wk[15:0]};
    endtask

    task automatic ms_tick();
        tick_ms = 1'b1;
        step();
        tick_ms = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R1 state in reset", state_o, 0);
        rst = 1'b0;
        step();
        chk("R1 state", state_o, 0);
        chk("R1 lpi_assert", lpi_assert, 0);
        chk("R1 tx_allowed", tx_allowed, 1);
        chk("R1 gate", txclk_gate_req, 0);
        chk("R1 pulses", {lpi_entry_pulse, lpi_exit_pulse}, 0);
    endtask

    task automatic t_one_enable();
        cfg_lpi_en = 1'b1; cfg_auto_en = 1'b0; cfg_link_up = 1'b1;
        repeat (4) step();
        chk("R3 single enable stays active", state_o, 0);
        cfg_lpi_en = 1'b0;
    endtask

    task automatic t_enter();
        set_times(3, 5);
        cfg_link_up = 1'b0;
        step();
        cfg_lpi_en = 1'b1; cfg_auto_en = 1'b1; cfg_link_up = 1'b1;
        step();
        chk("R3 R11 link-wait code", state_o, 1);
        ms_tick(); step();
        ms_tick(); step();
        chk("R4 two of three ticks", state_o, 1);
        ms_tick();
        chk("R4 last tick not yet idle", state_o, 1);
        step();
        chk("R4 R11 idle code", state_o, 2);
        chk("R10 entry pulse", lpi_entry_pulse, 1);
        chk("R4 lpi_assert", lpi_assert, 1);
        chk("R6 tx blocked in idle", tx_allowed, 0);
        step();
        chk("R10 entry pulse one cycle", lpi_entry_pulse, 0);
    endtask

    task automatic t_wake();
        int n;
        tx_pending = 1'b1;
        step();
        chk("R6 R11 wake code", state_o, 3);
        chk("R6 lpi low in wake", lpi_assert, 0);
        chk("R6 tx blocked in wake", tx_allowed, 0);
        chk("R10 exit pulse", lpi_exit_pulse, 1);
        n = 1;
        while (state_o == 2'd3 && n < 100000) begin
            step();
            if (state_o == 2'd3) n++;
        end
        chk("R7 R2 wake length W+1", n, 6);
        chk("R7 active after wake", state_o, 0);
        chk("R7 tx allowed after wake", tx_allowed, 1);
        step();
        repeat (3) step();
        chk("R5 pending holds link-wait", state_o, 1);
        tx_pending = 1'b0;
        step();
        chk("R5 idle after pending falls", state_o, 2);
    endtask

    task automatic t_gate();
        cfg_gate_en = 1'b0;
        step();
        chk("R9 no request without enable", txclk_gate_req, 0);
        cfg_gate_en = 1'b1;
        step();
        chk("R9 request in idle", txclk_gate_req, 1);
    endtask

    task automatic t_enable_clear();
        cfg_auto_en = 1'b0;
        step();
        chk("R6 enable cleared gives wake", state_o, 3);
        chk("R9 no request in wake", txclk_gate_req, 0);
        repeat (10) step();
        chk("R3 stays active unarmed", state_o, 0);
        cfg_auto_en = 1'b1;
        step();
        chk("R3 rearm link-wait", state_o, 1);
        step();
        chk("R4 met count re-enters", state_o, 2);
    endtask

    task automatic t_link_drop();
        cfg_link_up = 1'b0;
        step();
        chk("R8 active after drop", state_o, 0);
        chk("R8 lpi low after drop", lpi_assert, 0);
        chk("R10 exit pulse on drop", lpi_exit_pulse, 1);
        repeat (5) begin ms_tick(); step(); end
        chk("R4 no entry while link down", state_o, 0);
        cfg_link_up = 1'b1;
        step();
        chk("R8 link-wait after restore", state_o, 1);
        ms_tick(); step();
        ms_tick(); step();
        chk("R8 counter cleared by drop", state_o, 1);
        ms_tick(); step();
        chk("R4 full count enters idle", state_o, 2);
    endtask

    task automatic t_drop_in_wake();
        set_times(3, 200);
        tx_pending = 1'b1;
        step();
        chk("R6 wake for long count", state_o, 3);
        repeat (5) step();
        chk("R7 still waking", state_o, 3);
        cfg_link_up = 1'b0;
        step();
        chk("R8 drop ends wake", state_o, 0);
        chk("R8 tx allowed after drop", tx_allowed, 1);
        tx_pending = 1'b0;
    endtask

    task automatic t_zero_times();
        set_times(0, 0);
        cfg_link_up = 1'b1;
        step();
        chk("R4 zero count link-wait", state_o, 1);
        step();
        chk("R4 zero count idle at once", state_o, 2);
        tx_pending = 1'b1;
        step();
        chk("R7 zero wake entered", state_o, 3);
        step();
        chk("R7 zero wake lasts one cycle", state_o, 0);
        tx_pending = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_one_enable();
        t_enter();
        t_wake();
        t_gate();
        t_enable_clear();
        t_link_drop();
        t_drop_in_wake();
        t_zero_times();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule